// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog peripheral on a simple 16-bit register bus. Software arms it by choosing watchdog mode, a clock divider and the timer enable. From then on a prescaler advances an 8-bit up-counter, and software must reload the counter before it wraps. When the counter wraps, a sticky overflow flag is set. If reset assertion is enabled, the block also drives a fixed-length synchronous system reset pulse. After that pulse it clears its own timer enable.

Every register write carries a key byte in bits 15:8. A write with the wrong key is dropped. The overflow flag cannot be cleared by a blind write. Software must first read the reset-control register while the flag is set, and then write the special clear word. A supervisor can force a quick restart: it loads the counter with 255 at the fastest divider, so the wrap comes one prescaled tick later.

Top module: `keyed_wdt`

## Requirements
- R1: After reset all three registers read 0x0000 and `sys_reset_o` is low.
- R2: A write to offset 0 (control) takes effect only when bits 15:8 are 0xA5. A write to offset 2 (counter) or offset 4 (reset control) takes effect only when bits 15:8 are 0x5A. A write with any other key changes nothing.
- R3: Control register fields are: bit 6 = watchdog mode, bit 5 = timer enable, bits 2:0 = clock select. The counter advances only when both bit 6 and bit 5 are set. Writing 0xA500 stops it.
- R4: Clock selects 0 through 7 make the counter advance once every 1, 64, 128, 256, 512, 1024, 4096 and 16384 input clocks. The first advance comes exactly one full divider period after the start write.
- R5: The counter counts up. On the tick taken at value 255 it wraps to 0 and sets the sticky overflow flag, which is bit 7 of the reset-control register at offset 4.
- R6: A keyed counter write loads bits 7:0 into the counter and restarts the prescaler. Writing 0 is the keepalive, and the next advance is one full divider period after it.
- R7: When bit 6 of the reset-control register is set, an overflow raises `sys_reset_o` from the clock after the wrap, and it stays high for exactly PULSE_LEN (16) clocks. When bit 6 is clear, an overflow raises no pulse.
- R8: When the reset pulse ends, the timer-enable bit reads 0. Watchdog mode and clock select keep their values, and the counter stops.
- R9: Writing 0x A500 to offset 4 clears the overflow flag only if offset 4 was read (with `bus_rd`) while the flag was set. Otherwise the clear word is ignored. A new overflow re-arms the interlock.
- R10: Read data shows 0x00 in bits 15:8 and the register contents in bits 7:0. Control reads as {0, mode, enable, 00, select}. The counter reads as its value. Reset control reads as {flag, reset enable, 000000}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the prescaler source |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_rd | input | 1 | Read strobe; reading offset 4 arms the flag clear |
| bus_addr | input | 3 | Byte offset: 0 control, 2 counter, 4 reset control |
| bus_wdata | input | 16 | Key byte in 15:8, data in 7:0 |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| sys_reset_o | output | 1 | Active-high system reset pulse |

## Verification
The bench builds the block with its default parameters: a 14-bit prescaler and a 16-clock reset pulse. It preloads the counter just below the wrap point, so each divider setting shows its first tick within one period. This includes the slowest setting, which takes 16384 clocks and would otherwise need millions. Because the pulse length is 16, the whole pulse and the enable clear that follows it can be counted cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 8;

    localparam logic [7:0]  KEY_CTRL  = 8'hA5;
    localparam logic [7:0]  KEY_DATA  = 8'h5A;
    localparam logic [15:0] FLAG_CLR  = 16'hA500;

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_CNT  = 3'd2;
    localparam logic [2:0] OFS_RCTL = 3'd4;

    typedef struct packed {
        logic       wd_mode;
        logic       run_en;
        logic [2:0] sel;
    } ctrl_t;

    typedef struct packed {
        logic ovf;
        logic rst_en;
    } rctl_t;

    // log2 of the prescale ratio for each clock select
    function automatic logic [3:0] sel_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    return 4'd0;
            3'd1:    return 4'd6;
            3'd2:    return 4'd7;
            3'd3:    return 4'd8;
            3'd4:    return 4'd9;
            3'd5:    return 4'd10;
            3'd6:    return 4'd12;
            default: return 4'd14;
        endcase
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int PRE_W = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int LW = PRE_W + 1;

    logic [PRE_W-1:0] pre_q;
    logic [LW-1:0]    limit;

    always_comb begin
        limit = (LW'(1) << sel_shift(sel)) - LW'(1);
        tick  = run && !restart && ({1'b0, pre_q} == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active,
    output logic last
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
        else if (fire)
            left_q <= CW'(LEN);
    end

    assign active = (left_q != '0);
    assign last   = (left_q == CW'(1));
endmodule

// File: rtl/wdt_ovf_flag.sv
module wdt_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic seen_rd,
    input  logic clr_req,
    output logic flag,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (set_i) begin
            flag  <= 1'b1;
            armed <= 1'b0;
        end else if (clr_req && armed) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (seen_rd && flag) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int PRE_W     = 14,
    parameter int PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        sys_reset_o
);
    logic [7:0]        key;
    logic [DATA_W-1:0] wlo;
    logic              ctrl_we, cnt_we, rctl_we, clr_req, flag_rd;
    logic              run, tick, ovf_evt, pulse_last, ovf_flag, flag_armed;
    logic              run_en;

    ctrl_t             ctrl_q;
    logic              rst_en_q;
    logic [DATA_W-1:0] cnt_q;

    assign key     = bus_wdata[15:8];
    assign wlo     = bus_wdata[DATA_W-1:0];
    assign ctrl_we = bus_wr && (bus_addr == OFS_CTRL) && (key == KEY_CTRL);
    assign cnt_we  = bus_wr && (bus_addr == OFS_CNT)  && (key == KEY_DATA);
    assign rctl_we = bus_wr && (bus_addr == OFS_RCTL) && (key == KEY_DATA);
    assign clr_req = bus_wr && (bus_addr == OFS_RCTL) && (bus_wdata == FLAG_CLR);
    assign flag_rd = bus_rd && (bus_addr == OFS_RCTL);
    assign run     = ctrl_q.wd_mode && ctrl_q.run_en;
    assign run_en  = ctrl_q.run_en;
    assign ovf_evt = tick && (cnt_q == '1);

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (cnt_we),
        .sel     (ctrl_q.sel),
        .tick    (tick)
    );

    wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (ovf_evt && rst_en_q),
        .active (sys_reset_o),
        .last   (pulse_last)
    );

    wdt_ovf_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_i   (ovf_evt),
        .seen_rd (flag_rd),
        .clr_req (clr_req),
        .flag    (ovf_flag),
        .armed   (flag_armed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_we)
                ctrl_q <= '{wd_mode: wlo[6], run_en: wlo[5], sel: wlo[2:0]};
            if (pulse_last)
                ctrl_q.run_en <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_we)
            cnt_q <= wlo;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rst_en_q <= 1'b0;
        else if (rctl_we)
            rst_en_q <= wlo[6];
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = {8'h00, 1'b0, ctrl_q.wd_mode, ctrl_q.run_en, 2'b00, ctrl_q.sel};
            OFS_CNT:  bus_rdata = {8'h00, cnt_q};
            OFS_RCTL: bus_rdata = {8'h00, ovf_flag, rst_en_q, 6'b000000};
            default:  bus_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
    parameter int PULSE_LEN = 16
) (
    input logic clk,
    input logic rst,
    input logic sys_reset_o,
    input logic ovf_evt,
    input logic ovf_flag,
    input logic flag_armed,
    input logic clr_req,
    input logic rst_en_q,
    input logic run_en
);
    logic [15:0] high_len;

    always_ff @(posedge clk) begin
        if (rst || !sys_reset_o)
            high_len <= '0;
        else
            high_len <= high_len + 1'b1;
    end

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_reset_o) |-> $past(ovf_evt && rst_en_q));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_reset_o) |-> (high_len == 16'(PULSE_LEN)));

    // R7
    no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && !rst_en_q && !sys_reset_o) |=> !sys_reset_o);

    // R8
    enable_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_reset_o) |-> !run_en);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(flag_armed && clr_req));
endmodule

bind keyed_wdt keyed_wdt_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sys_reset_o (sys_reset_o),
    .ovf_evt     (ovf_evt),
    .ovf_flag    (ovf_flag),
    .flag_armed  (flag_armed),
    .clr_req     (clr_req),
    .rst_en_q    (rst_en_q),
    .run_en      (run_en)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        sys_reset_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    keyed_wdt dut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .sys_reset_o (sys_reset_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int div_of(input int s);
        case (s)
            0: return 1;
            1: return 64;
            2: return 128;
            3: return 256;
            4: return 512;
            5: return 1024;
            6: return 4096;
            default: return 16384;
        endcase
    endfunction

    task automatic t_reset_state();
        logic [15:0] v;
        peek(3'd0, v); chk("R1 ctrl", v, 16'h0000);
        peek(3'd2, v); chk("R1 counter", v, 16'h0000);
        peek(3'd4, v); chk("R1 rctl", v, 16'h0000);
        chk("R1 reset out", {15'd0, sys_reset_o}, 16'h0000);
    endtask

    task automatic t_keys();
        logic [15:0] v;
        wr(3'd0, 16'h5A67); peek(3'd0, v); chk("R2 ctrl wrong key", v, 16'h0000);
        wr(3'd2, 16'hA512); peek(3'd2, v); chk("R2 counter wrong key", v, 16'h0000);
        wr(3'd4, 16'hA540); peek(3'd4, v); chk("R2 rctl wrong key", v, 16'h0000);
        wr(3'd0, 16'hA507); peek(3'd0, v); chk("R2 R10 ctrl keyed", v, 16'h0007);
        wr(3'd2, 16'h5A12); peek(3'd2, v); chk("R2 R10 counter keyed", v, 16'h0012);
        wr(3'd4, 16'h5A40); peek(3'd4, v); chk("R2 R10 rctl keyed", v, 16'h0040);
        wr(3'd4, 16'h5A00);
        wr(3'd0, 16'hA500);
    endtask

    task automatic t_mode_gate();
        logic [15:0] v, w;
        wr(3'd2, 16'h5A00);
        wr(3'd0, 16'hA520); wait_cyc(10); peek(3'd2, v);
        chk("R3 enable without mode", v, 16'h0000);
        wr(3'd0, 16'hA540); wait_cyc(10); peek(3'd2, v);
        chk("R3 mode without enable", v, 16'h0000);
        wr(3'd0, 16'hA560); wait_cyc(10); peek(3'd2, v);
        chk("R3 running div1", v, 16'h000A);
        wr(3'd0, 16'hA500); peek(3'd2, v); wait_cyc(10); peek(3'd2, w);
        chk("R3 stopped holds", w, v);
    endtask

    task automatic t_dividers();
        logic [15:0] v;
        for (int s = 0; s < 8; s++) begin
            wr(3'd0, 16'hA500);
            wr(3'd2, 16'h5A10);
            wr(3'd0, 16'hA560 | 16'(s));
            wait_cyc(div_of(s) - 1); peek(3'd2, v);
            chk($sformatf("R4 sel%0d before tick", s), v, 16'h0010);
            wait_cyc(1); peek(3'd2, v);
            chk($sformatf("R4 sel%0d at tick", s), v, 16'h0011);
        end
        wr(3'd0, 16'hA500);
    endtask

    task automatic t_overflow_quiet();
        logic [15:0] v;
        int hi = 0;
        wr(3'd4, 16'h5A00);
        wr(3'd2, 16'h5AFD);
        wr(3'd0, 16'hA560);
        wait_cyc(2); peek(3'd2, v); chk("R5 at 255", v, 16'h00FF);
        peek(3'd4, v); chk("R5 flag before wrap", v, 16'h0000);
        wait_cyc(1); peek(3'd2, v); chk("R5 wrapped", v, 16'h0000);
        peek(3'd4, v); chk("R5 flag set", v, 16'h0080);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (sys_reset_o) hi++;
        end
        chk("R7 no pulse when disabled", 16'(hi), 16'h0000);
        wr(3'd0, 16'hA500);
        peek(3'd4, v); chk("R5 flag sticky", v, 16'h0080);
    endtask

    task automatic t_clear_interlock();
        logic [15:0] v;
        wr(3'd4, 16'hA500); peek(3'd4, v);
        chk("R9 blind clear ignored", v, 16'h0080);
        rd(3'd4, v); chk("R9 read flag", v, 16'h0080);
        wr(3'd4, 16'hA500); peek(3'd4, v);
        chk("R9 clear after read", v, 16'h0000);
    endtask

    task automatic t_keepalive();
        logic [15:0] v;
        wr(3'd2, 16'h5A00);
        wr(3'd0, 16'hA561);
        wait_cyc(100); peek(3'd2, v); chk("R6 counting", v, 16'h0001);
        wr(3'd2, 16'h5A00); peek(3'd2, v); chk("R6 keepalive loads 0", v, 16'h0000);
        wait_cyc(63); peek(3'd2, v); chk("R6 prescaler restarted", v, 16'h0000);
        wait_cyc(1); peek(3'd2, v); chk("R6 first tick after keepalive", v, 16'h0001);
        wr(3'd0, 16'hA500);
    endtask

    task automatic t_reset_pulse();
        logic [15:0] v, w;
        int hi = 0;
        int first = -1;
        wr(3'd4, 16'h5A40);
        wr(3'd2, 16'h5AFF);
        wr(3'd0, 16'hA560);
        chk("R7 low before wrap", {15'd0, sys_reset_o}, 16'h0000);
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (sys_reset_o) begin
                hi++;
                if (first < 0) first = i;
            end
        end
        chk("R7 pulse length", 16'(hi), 16'd16);
        chk("R7 pulse start", 16'(first), 16'd1);
        peek(3'd0, v); chk("R8 enable cleared", v, 16'h0040);
        peek(3'd2, v); wait_cyc(10); peek(3'd2, w);
        chk("R8 counter stopped", w, v);
        peek(3'd4, v); chk("R5 R7 flag with reset enable", v, 16'h00C0);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        t_reset_state();
        t_keys();
        t_mode_gate();
        t_dividers();
        t_overflow_quiet();
        t_clear_interlock();
        t_keepalive();
        t_reset_pulse();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule